// File: doc/BRIEF.md
# Command-Driven SPI Master Engine

This block is the shifting core of an SPI master. Every frame arrives as one 32-bit queue entry. The upper half is a command word and the lower half is the data to transmit. The command picks the chip-select line to drive and the attribute set that shapes the frame. It also says whether the select stays asserted once the frame ends, whether the frame closes the queue, and whether the transfer counter restarts. The engine drives SCK, MOSI and the chip-select lines, samples MISO, and returns each received word on a result stream.

Entries arrive on a valid/ready stream. The engine takes one only when it is idle and the previous received word has been consumed. A consumer that holds `rx_ready` low therefore stalls the entry stream after one frame. A received word stays on `rx_data` with `rx_valid` high until `rx_ready` is seen high at a clock edge. The SCK edge pacing comes from a neighbouring timing block as the `half_tick` strobe: one strobe per SCK half period. The entry FIFO sits upstream.

Software-visible state is exposed as plain ports. The transfer count appears in bits [31:16] of `tcr`. Two sticky flags appear in `status` and are cleared by writing ones to `status_clr`.

Top module: `cmdspi_engine`

## Requirements
- R1: An entry is taken on a clock edge where both `entry_valid` and `entry_ready` are high. `entry_ready` is high only when no frame is in progress and `rx_valid` is low.
- R2: Command bits [5:0] (entry bits [21:16]) are a one-hot select mask. From the cycle after acceptance, each selected line of `pcs` is driven to the inverse of its `cs_idle` bit. Every unselected line of `pcs` stays equal to its `cs_idle` bit.
- R3: If command bit 15 (the hold flag) is set, the selected lines stay active after the frame until the next entry is accepted. If it is clear, every line of `pcs` returns to its `cs_idle` level in the cycle after the final SCK edge.
- R4: Command bits [14:12] pick one of the 32-bit words in `attr_sets`. The picked word is decoded as follows:
  - bits [30:27] hold the frame length minus one;
  - field values 0, 1 and 2 give a 4-bit frame;
  - bit 26 is the clock idle level;
  - bit 25 is the phase;
  - bit 24 selects least-significant-bit-first order.
- R5: SCK takes the idle level of the picked attribute set in the cycle after acceptance. It toggles once per `half_tick` while shifting and makes exactly 2N toggles for an N-bit frame. It does not change while the engine is idle.
- R6: With phase 0, the first bit is on MOSI before the first SCK edge, MISO is sampled on the leading edges, and MOSI advances on the trailing edges. With phase 1, MOSI advances on each leading edge after the first, and MISO is sampled on the trailing edges. MOSI is low while the engine is idle.
- R7: The transmitted bits are the low N bits of entry bits [15:0]. They go out most significant first, or least significant first when the order bit is set.
- R8: In the cycle after the final edge, `rx_valid` rises. `rx_data` then holds the N sampled bits, mapped with the same bit order, and every bit above N reads zero. Both stay unchanged until the word is taken.
- R9: The counter in `tcr[31:16]` increments by one for each completed frame. If command bit 10 is set, the counter is zeroed before that frame is counted, so it reads 1 after the frame.
- R10: `status` bit 31 is set after every completed frame. `status` bit 28 is set after a frame whose command bit 11 is set. A one in the same position of `status_clr` clears the flag. A set in the same cycle wins over the clear.
- R11: During reset, the outputs read as follows: `pcs` equals `cs_idle`; SCK, MOSI and `rx_valid` are low; `entry_ready` is high; the counter and both flags are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| entry_valid | input | 1 | Queue entry offered |
| entry_ready | output | 1 | Engine accepts the entry this cycle |
| entry_data | input | 32 | Command in [31:16], transmit data in [15:0] |
| attr_sets | input | 32*ATTR_SETS | Frame attribute words, set k in bits [32k+31:32k] |
| cs_idle | input | NUM_CS | Idle level of each chip-select line |
| half_tick | input | 1 | One strobe per SCK half period |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| pcs | output | NUM_CS | Chip-select lines |
| miso | input | 1 | Serial data in |
| rx_valid | output | 1 | Received word available |
| rx_ready | input | 1 | Consumer takes the received word |
| rx_data | output | 16 | Received word, zero above the frame length |
| tcr | output | 32 | Transfer counter in [31:16], zero below |
| status | output | 32 | Frame-done flag in bit 31, end-of-queue flag in bit 28 |
| status_clr | input | 32 | Write-one-to-clear mask for `status` |

## Verification
Frames are sent through all four combinations of clock idle level and phase, in both bit orders, and at lengths of 4, 8, 12 and 16 bits, plus length fields below 3. Mixing these is what separates a wrong drive-edge or sample-edge choice from a wrong bit-slot mapping. MISO is fed either from MOSI in loopback or from a pseudo-random source. Loopback pins down the masking of bits above the frame length. Random input exposes samples taken on the wrong edge. The strobe spacing, the consumer's readiness, the idle levels and the same-cycle flag clears are varied as well, so that back-pressure, chip-select holding and the set-over-clear priority are exercised against a cycle-exact model.

// File: rtl/cmdspi_pkg.sv
package cmdspi_pkg;
  localparam int WORD_W = 16;
  localparam int NB_W   = $clog2(WORD_W + 1);
  localparam int CNT_W  = 16;

  // Command word bit positions (within the upper half of an entry)
  localparam int CMD_HOLD   = 15;
  localparam int CMD_SET_LO = 12;
  localparam int CMD_LAST   = 11;
  localparam int CMD_CNTCLR = 10;

  // Attribute word bit positions
  localparam int ATT_LEN_LO = 27;
  localparam int ATT_CPOL   = 26;
  localparam int ATT_CPHA   = 25;
  localparam int ATT_LSBF   = 24;

  // Status bit positions
  localparam int STS_FRAME = 31;
  localparam int STS_QEND  = 28;

  typedef struct packed {
    logic [NB_W-1:0] nbits;
    logic            cpol;
    logic            cpha;
    logic            lsbf;
  } frame_fmt_t;

  function automatic frame_fmt_t decode_fmt(input logic [31:0] a);
    frame_fmt_t f;
    logic [3:0] len_m1;
    len_m1  = a[ATT_LEN_LO +: 4];
    f.nbits = (len_m1 < 4'd3) ? NB_W'(4) : NB_W'(len_m1) + NB_W'(1);
    f.cpol  = a[ATT_CPOL];
    f.cpha  = a[ATT_CPHA];
    f.lsbf  = a[ATT_LSBF];
    return f;
  endfunction
endpackage

// File: rtl/cmdspi_shifter.sv
module cmdspi_shifter
  import cmdspi_pkg::*;
#(
  parameter int EDGE_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] load_word,
  input  logic [NB_W-1:0]   nbits,
  input  logic              cpha,
  input  logic              lsbf,
  input  logic              active,
  input  logic              edge_stb,
  input  logic [EDGE_W-1:0] edge_idx,
  input  logic              miso,
  output logic              mosi,
  output logic [WORD_W-1:0] rx_word
);
  localparam int IDX_W = $clog2(WORD_W);

  logic [WORD_W-1:0] tx_q;
  logic [WORD_W-1:0] rx_q;
  logic [EDGE_W-1:0] drv_edge;
  logic [IDX_W-1:0]  drv_ord;
  logic [IDX_W-1:0]  smp_ord;

  // Map the position of a bit on the wire to its slot in the word
  function automatic logic [IDX_W-1:0] bit_slot(input logic [IDX_W-1:0] ord,
                                                input logic lsb_first,
                                                input logic [NB_W-1:0] len);
    return lsb_first ? ord : IDX_W'(len - NB_W'(1) - NB_W'(ord));
  endfunction

  // Phase 1 moves to the next bit only on leading edges after the first
  assign drv_edge = (cpha && edge_idx != '0) ? edge_idx - 1'b1 : edge_idx;
  assign drv_ord  = IDX_W'(drv_edge >> 1);
  assign smp_ord  = IDX_W'(edge_idx >> 1);

  assign mosi    = active & tx_q[bit_slot(drv_ord, lsbf, nbits)];
  assign rx_word = rx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q <= '0;
      rx_q <= '0;
    end else if (load) begin
      tx_q <= load_word;
      rx_q <= '0;
    end else if (edge_stb && (edge_idx[0] == cpha)) begin
      rx_q[bit_slot(smp_ord, lsbf, nbits)] <= miso;
    end
  end
endmodule

// File: rtl/cmdspi_status.sv
module cmdspi_status
  import cmdspi_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_done,
  input  logic             cnt_clear,
  input  logic             queue_end,
  input  logic             clr_frame,
  input  logic             clr_queue,
  output logic [CNT_W-1:0] count,
  output logic             frame_flag,
  output logic             queue_flag
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count      <= '0;
      frame_flag <= 1'b0;
      queue_flag <= 1'b0;
    end else begin
      if (frame_done) count <= (cnt_clear ? '0 : count) + 1'b1;
      frame_flag <= frame_done | (frame_flag & ~clr_frame);
      queue_flag <= (frame_done & queue_end) | (queue_flag & ~clr_queue);
    end
  end
endmodule

// File: rtl/cmdspi_engine.sv
module cmdspi_engine
  import cmdspi_pkg::*;
#(
  parameter int NUM_CS    = 6,
  parameter int ATTR_SETS = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   entry_valid,
  output logic                   entry_ready,
  input  logic [31:0]            entry_data,
  input  logic [ATTR_SETS*32-1:0] attr_sets,
  input  logic [NUM_CS-1:0]      cs_idle,
  input  logic                   half_tick,
  output logic                   sck,
  output logic                   mosi,
  output logic [NUM_CS-1:0]      pcs,
  input  logic                   miso,
  output logic                   rx_valid,
  input  logic                   rx_ready,
  output logic [WORD_W-1:0]      rx_data,
  output logic [31:0]            tcr,
  output logic [31:0]            status,
  input  logic [31:0]            status_clr
);
  localparam int SEL_W  = (ATTR_SETS > 1) ? $clog2(ATTR_SETS) : 1;
  localparam int EDGE_W = $clog2(2 * WORD_W + 1);

  logic              busy;
  frame_fmt_t        fmt;
  frame_fmt_t        next_fmt;
  logic              keep_sel;
  logic              end_q;
  logic              clr_cnt;
  logic [EDGE_W-1:0] edge_idx;
  logic [NUM_CS-1:0] sel_act;
  logic [SEL_W-1:0]  set_idx;
  logic              accept;
  logic              edge_stb;
  logic              last_edge;
  logic [CNT_W-1:0]  count;
  logic              frame_flag;
  logic              queue_flag;
  logic              unused_bits;

  assign set_idx  = entry_data[16 + CMD_SET_LO +: SEL_W];
  assign next_fmt = decode_fmt(attr_sets[int'(set_idx) * 32 +: 32]);

  assign entry_ready = !busy && !rx_valid;
  assign accept      = entry_valid && entry_ready;
  assign edge_stb    = busy && half_tick;
  assign last_edge   = edge_stb && (edge_idx == EDGE_W'(2 * fmt.nbits - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      fmt      <= '0;
      keep_sel <= 1'b0;
      end_q    <= 1'b0;
      clr_cnt  <= 1'b0;
      edge_idx <= '0;
      sel_act  <= '0;
      sck      <= 1'b0;
      rx_valid <= 1'b0;
    end else begin
      if (rx_valid && rx_ready) rx_valid <= 1'b0;
      if (accept) begin
        busy     <= 1'b1;
        fmt      <= next_fmt;
        keep_sel <= entry_data[16 + CMD_HOLD];
        end_q    <= entry_data[16 + CMD_LAST];
        clr_cnt  <= entry_data[16 + CMD_CNTCLR];
        edge_idx <= '0;
        sel_act  <= entry_data[16 +: NUM_CS];
        sck      <= next_fmt.cpol;
      end else if (edge_stb) begin
        sck      <= ~sck;
        edge_idx <= edge_idx + 1'b1;
        if (last_edge) begin
          busy     <= 1'b0;
          rx_valid <= 1'b1;
          if (!keep_sel) sel_act <= '0;
        end
      end
    end
  end

  for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
    assign pcs[g] = sel_act[g] ? ~cs_idle[g] : cs_idle[g];
  end

  cmdspi_shifter #(.EDGE_W(EDGE_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept),
    .load_word(entry_data[WORD_W-1:0]),
    .nbits    (fmt.nbits),
    .cpha     (fmt.cpha),
    .lsbf     (fmt.lsbf),
    .active   (busy),
    .edge_stb (edge_stb),
    .edge_idx (edge_idx),
    .miso     (miso),
    .mosi     (mosi),
    .rx_word  (rx_data)
  );

  cmdspi_status u_status (
    .clk       (clk),
    .rst_n     (rst_n),
    .frame_done(last_edge),
    .cnt_clear (clr_cnt),
    .queue_end (end_q),
    .clr_frame (status_clr[STS_FRAME]),
    .clr_queue (status_clr[STS_QEND]),
    .count     (count),
    .frame_flag(frame_flag),
    .queue_flag(queue_flag)
  );

  assign tcr = {count, 16'h0000};

  always_comb begin
    status            = '0;
    status[STS_FRAME] = frame_flag;
    status[STS_QEND]  = queue_flag;
  end

  assign unused_bits = ^{entry_data[25:22], status_clr[30:29], status_clr[27:0], fmt.cpol};
endmodule

// File: rtl/cmdspi_engine_chk.sv
module cmdspi_engine_chk #(
  parameter int NUM_CS = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              last_edge,
  input logic              keep_sel,
  input logic              end_q,
  input logic              entry_valid,
  input logic              entry_ready,
  input logic              rx_valid,
  input logic              rx_ready,
  input logic [15:0]       rx_data,
  input logic              sck,
  input logic              mosi,
  input logic [NUM_CS-1:0] pcs,
  input logic [NUM_CS-1:0] cs_idle,
  input logic [15:0]       cnt,
  input logic              st_frame,
  input logic              st_queue
);
  p_ready_blocked_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> !entry_ready);

  p_one_select_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pcs ^ cs_idle));

  p_cs_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (last_edge && !keep_sel) |=> (pcs == cs_idle));

  p_sck_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !(entry_valid && entry_ready)) |=> $stable(sck));

  p_mosi_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mosi);

  p_rx_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data)));

  p_cnt_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    last_edge |=> ((cnt == $past(cnt) + 16'd1) || (cnt == 16'd1)));

  p_cnt_still_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !last_edge |=> $stable(cnt));

  p_frame_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
    last_edge |=> st_frame);

  p_queue_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (last_edge && end_q) |=> st_queue);
endmodule

bind cmdspi_engine cmdspi_engine_chk #(.NUM_CS(NUM_CS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .busy       (busy),
  .last_edge  (last_edge),
  .keep_sel   (keep_sel),
  .end_q      (end_q),
  .entry_valid(entry_valid),
  .entry_ready(entry_ready),
  .rx_valid   (rx_valid),
  .rx_ready   (rx_ready),
  .rx_data    (rx_data),
  .sck        (sck),
  .mosi       (mosi),
  .pcs        (pcs),
  .cs_idle    (cs_idle),
  .cnt        (tcr[31:16]),
  .st_frame   (status[31]),
  .st_queue   (status[28])
);

// File: tb/cmdspi_engine_tb.sv
module cmdspi_engine_tb_top;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic         rst_n = 1'b0;
  logic         entry_valid = 1'b0;
  logic         entry_ready;
  logic [31:0]  entry_data = '0;
  logic [255:0] attr_sets = '0;
  logic [5:0]   cs_idle = 6'b000101;
  logic         half_tick = 1'b0;
  logic         sck, mosi, miso;
  logic [5:0]   pcs;
  logic         rx_valid;
  logic         rx_ready = 1'b1;
  logic [15:0]  rx_data;
  logic [31:0]  tcr, status;
  logic [31:0]  status_clr = '0;

  logic lb_en = 1'b1;
  logic rnd_bit = 1'b0;
  logic rr_rand = 1'b0;
  int   tcnt = 0;
  int   tick_per = 1;
  int   n_chk = 0;
  int   n_fail = 0;
  bit   ended = 0;

  assign miso = lb_en ? mosi : rnd_bit;

  cmdspi_engine dut_i (
    .clk(clk), .rst_n(rst_n), .entry_valid(entry_valid), .entry_ready(entry_ready),
    .entry_data(entry_data), .attr_sets(attr_sets), .cs_idle(cs_idle),
    .half_tick(half_tick), .sck(sck), .mosi(mosi), .pcs(pcs), .miso(miso),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .tcr(tcr), .status(status), .status_clr(status_clr)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  // Strobe, random MISO and consumer readiness, changed away from the edge
  always @(posedge clk) begin
    #2;
    tcnt++;
    half_tick = ((tcnt % tick_per) == 0);
    rnd_bit = 1'($urandom);
    if (rr_rand) rx_ready = (($urandom % 4) != 0);
  end

  // Behavioural reference model, stepped on the falling edge
  bit          m_busy = 0, m_rxv = 0, m_sck = 0, m_cpha = 0, m_lsb = 0;
  bit          m_cont = 0, m_eoq = 0, m_clr = 0, m_tcf = 0, m_qf = 0;
  int          m_n = 4, m_edges = 0;
  logic [5:0]  m_sel = '0;
  logic [15:0] m_rxd = '0, m_cnt = '0;
  bit          txq[$];
  bit          rxb[$];

  always @(negedge clk) begin
    logic        m_ready;
    logic [31:0] m_status;
    logic [31:0] att;
    int          k;
    m_ready  = !m_busy && !m_rxv;
    m_status = '0;
    m_status[31] = m_tcf;
    m_status[28] = m_qf;
    chk("R1 entry_ready", 32'(entry_ready), 32'(m_ready));
    chk("R3 pcs", 32'(pcs), 32'(cs_idle ^ m_sel));
    chk("R5 sck", 32'(sck), 32'(m_sck));
    chk("R7 mosi", 32'(mosi), 32'((m_busy && txq.size() > 0) ? txq[0] : 1'b0));
    chk("R8 rx_valid", 32'(rx_valid), 32'(m_rxv));
    if (m_rxv) chk("R8 rx_data", 32'(rx_data), 32'(m_rxd));
    chk("R9 count", tcr, {m_cnt, 16'h0});
    chk("R10 status", status, m_status);

    if (!rst_n) begin
      m_busy = 0; m_rxv = 0; m_sck = 0; m_tcf = 0; m_qf = 0;
      m_sel = '0; m_cnt = '0; m_rxd = '0;
      txq.delete(); rxb.delete();
    end else begin
      if (m_rxv && rx_ready) m_rxv = 0;
      if (status_clr[31]) m_tcf = 0;
      if (status_clr[28]) m_qf = 0;
      if (m_ready && entry_valid) begin
        att    = attr_sets[32*int'(entry_data[30:28]) +: 32];
        m_n    = int'(att[30:27]) + 1;
        if (m_n < 4) m_n = 4;
        m_sck  = att[26];
        m_cpha = att[25];
        m_lsb  = att[24];
        m_cont = entry_data[31];
        m_eoq  = entry_data[27];
        m_clr  = entry_data[26];
        m_sel  = entry_data[21:16];
        m_edges = 0;
        m_busy = 1;
        txq.delete(); rxb.delete();
        for (int i = 0; i < m_n; i++)
          txq.push_back(m_lsb ? entry_data[i] : entry_data[m_n-1-i]);
      end else if (m_busy && half_tick) begin
        k = m_edges;
        if ((k % 2) == int'(m_cpha)) rxb.push_back(miso);
        m_sck = !m_sck;
        m_edges++;
        if (((!m_cpha && (k % 2) == 1) || (m_cpha && (k % 2) == 0 && k > 0)) && txq.size() > 1)
          void'(txq.pop_front());
        if (m_edges == 2 * m_n) begin
          m_rxd = '0;
          for (int i = 0; i < m_n; i++) m_rxd[m_lsb ? i : m_n-1-i] = rxb[i];
          m_rxv  = 1;
          m_cnt  = (m_clr ? 16'd0 : m_cnt) + 16'd1;
          m_tcf  = 1;
          if (m_eoq) m_qf = 1;
          if (!m_cont) m_sel = '0;
          m_busy = 0;
        end
      end
    end
  end

  // Offer an entry and hold it until the edge that takes it
  task automatic send(input logic [15:0] cmd, input logic [15:0] data);
    @(posedge clk); #2;
    entry_valid = 1'b1;
    entry_data  = {cmd, data};
    forever begin
      if (entry_ready) begin
        @(posedge clk);
        break;
      end
      @(posedge clk); #2;
    end
    #2 entry_valid = 1'b0;
  endtask

  task automatic wait_rx();
    for (int i = 0; i < 2000; i++) begin
      @(posedge clk); #3;
      if (rx_valid) break;
    end
  endtask

  function automatic logic [31:0] mk_attr(input int len, input bit cpol, input bit cpha, input bit lsb);
    return (32'(len - 1) << 27) | (32'(cpol) << 26) | (32'(cpha) << 25) | (32'(lsb) << 24);
  endfunction

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    attr_sets[0*32 +: 32] = mk_attr(8, 0, 0, 0);
    attr_sets[1*32 +: 32] = mk_attr(16, 1, 1, 1);
    attr_sets[2*32 +: 32] = 32'(1) << 27 | (32'(1) << 25); // length field 1 -> clamped to 4
    attr_sets[3*32 +: 32] = mk_attr(12, 1, 0, 1);
    attr_sets[4*32 +: 32] = mk_attr(16, 0, 1, 0);
    attr_sets[5*32 +: 32] = mk_attr(5, 1, 1, 0);
    attr_sets[6*32 +: 32] = mk_attr(9, 0, 0, 1);
    attr_sets[7*32 +: 32] = 32'h0;

    // R11 reset state
    repeat (3) @(posedge clk);
    #3;
    chk("R11 pcs at reset", 32'(pcs), 32'(6'b000101));
    chk("R11 sck at reset", 32'(sck), 0);
    chk("R11 mosi at reset", 32'(mosi), 0);
    chk("R11 ready at reset", 32'(entry_ready), 1);
    chk("R11 rx_valid at reset", 32'(rx_valid), 0);
    chk("R11 tcr at reset", tcr, 0);
    chk("R11 status at reset", status, 0);
    @(posedge clk); #2 rst_n = 1'b1;

    // R2 select and R7 first bit MSB-first, R8 length masking
    send(16'h0008, 16'h1280);
    #3;
    chk("R2 pcs after accept", 32'(pcs), 32'(6'b001101));
    chk("R7 first bit msb-first", 32'(mosi), 1);
    wait_rx();
    chk("R8 rx masked to 8 bits", 32'(rx_data), 32'h80);

    // R7 LSB-first, 12-bit, idle level 1
    send(16'h3001, 16'h0001);
    #3;
    chk("R7 first bit lsb-first", 32'(mosi), 1);
    chk("R5 sck idles at cpol", 32'(sck), 1);
    wait_rx();
    chk("R7 rx lsb-first word", 32'(rx_data), 32'h001);

    // R4 length clamp
    send(16'h2002, 16'hFFFF);
    wait_rx();
    chk("R4 clamped 4-bit frame", 32'(rx_data), 32'h000F);

    // R3 hold then release
    send(16'h8010, 16'h0055);
    wait_rx();
    chk("R3 select held", 32'(pcs), 32'(6'b010101));
    send(16'h0010, 16'h00AA);
    wait_rx();
    chk("R3 select released", 32'(pcs), 32'(6'b000101));
    chk("R9 five frames counted", tcr, 32'h0005_0000);

    // R9 counter clear
    send(16'h0401, 16'h0033);
    wait_rx();
    @(posedge clk); #3;
    chk("R9 counter restarted", tcr, 32'h0001_0000);

    // R10 end-of-queue flag and write-one-to-clear
    send(16'h0801, 16'h0033);
    wait_rx();
    @(posedge clk); #3;
    chk("R10 queue flag set", 32'(status[28]), 1);
    status_clr = 32'h1000_0000;
    @(posedge clk); #2 status_clr = '0;
    #1;
    chk("R10 queue flag cleared", 32'(status[28]), 0);
    chk("R10 frame flag kept", 32'(status[31]), 1);
    status_clr = 32'h8000_0000;
    @(posedge clk); #2 status_clr = '0;
    #1;
    chk("R10 frame flag cleared", 32'(status[31]), 0);

    // R1 and R8 back-pressure
    rx_ready = 1'b0;
    send(16'h0001, 16'h00A5);
    wait_rx();
    entry_valid = 1'b1;
    entry_data  = 32'h0001_0011;
    repeat (3) @(posedge clk);
    #3;
    chk("R1 ready low while word unread", 32'(entry_ready), 0);
    chk("R8 word held", 32'(rx_data), 32'h00A5);
    entry_valid = 1'b0;
    rx_ready = 1'b1;
    @(posedge clk); #3;
    chk("R8 word taken", 32'(rx_valid), 0);

    // R6 phases, mixed patterns against the model
    lb_en = 1'b0;
    rr_rand = 1'b1;
    for (int f = 0; f < 48; f++) begin
      logic [15:0] cmd;
      tick_per = 1 + (f % 4);
      if ((f % 11) == 5) cs_idle = 6'($urandom);
      cmd = 16'h0;
      cmd[15]    = 1'($urandom);
      cmd[14:12] = 3'($urandom);
      cmd[11]    = 1'($urandom);
      cmd[10]    = (($urandom % 8) == 0);
      cmd[5:0]   = (($urandom % 7) == 6) ? 6'd0 : 6'd1 << ($urandom % 6);
      send(cmd, 16'($urandom));
      if ((f % 5) == 2) begin
        status_clr = {1'($urandom), 2'b0, 1'($urandom), 28'h0};
        @(posedge clk); #2 status_clr = '0;
      end
    end
    rr_rand = 1'b0;
    rx_ready = 1'b1;
    repeat (200) @(posedge clk);
    finish_run();
  end
endmodule